// File: doc/BRIEF.md
# Pseudo-static RAM mode and refresh controller

This block is the control core of a pseudo-static RAM: a DRAM cell array presented to the system as a plain, non-multiplexed static RAM. It decodes the chip enable, the read/write select and a shared output-enable/refresh pin into one of six operating modes. From that mode it drives a row-select address and a row activate strobe toward the array, along with data-bus enables. All of this runs on one free-running clock, and the control inputs are expected to be synchronous to that clock.

An external access (write, read, or a refresh of the addressed row alone) runs one row cycle at the low address bits each time chip enable goes low. With chip enable high, a short low pulse on the refresh pin refreshes the row held in an internal wrapping counter and then advances that counter. If the pin stays low past a length threshold, the block switches to self refresh. In self refresh an internal timer issues one counter-driven row cycle per interval, chosen so that every row is visited inside the retention window. The row sequencer runs one row cycle at a time. An internal refresh that has started always completes before an external access is accepted.

Top module: `psram_ctrl`

## Requirements
- R1: `row_addr_o` of an external row cycle equals `addr_i[ROW_W-1:0]` as sampled when the cycle starts, and `col_addr_o` always equals the upper `COL_W` address bits.
- R2: Chip enable low with `rw_i` low is a write: `mode_o` = 1, `wr_en_o` = 1 and `dout_en_o` = 0, one cycle after the inputs are sampled.
- R3: Chip enable low, `rw_i` high and `oe_rfsh_ni` low is a read: `mode_o` = 2 and `dout_en_o` = 1, one cycle after the inputs are sampled.
- R4: Chip enable low, `rw_i` high and `oe_rfsh_ni` high refreshes only the externally addressed row: `mode_o` = 3, one row cycle at that row, and `dout_en_o` = 0.
- R5: With chip enable high, each falling edge of `oe_rfsh_ni` starts one row cycle at the internal counter and advances the counter by one. The counter is 0 after reset and wraps from 255 to 0. While the pin is low and below the threshold, `mode_o` = 4.
- R6: A refresh-pin low time of THRESH_CYC = LONG_PULSE_US*CLK_PER_US samples or more enters self refresh (`mode_o` = 5). A shorter low time never reports `mode_o` = 5.
- R7: In self refresh, counter-driven row cycles follow one another every INTERVAL_CYC = RETENTION_US*CLK_PER_US/2^ROW_W clocks, and the counter keeps advancing.
- R8: When `oe_rfsh_ni` returns high, self refresh ends: no further row cycles are started and `mode_o` = 0 (standby).
- R9: Standby (chip enable and refresh pin both high) starts no row cycle and keeps `dout_en_o` and `wr_en_o` low.
- R10: Each row cycle holds `row_act_o` high for exactly ROW_CYC clocks with `row_addr_o` stable, and is followed by at least one idle clock.
- R11: A pending internal refresh is served before an external access. The external row cycle starts only after the internal one has finished.
- R12: Only one external row cycle is run per chip-enable-low period, however long chip enable stays low.
- R13: Toggling `oe_rfsh_ni` while chip enable is low neither starts a counter-driven refresh nor advances the counter.
- R14: After reset, `mode_o` = 0, `row_act_o` = 0, `dout_en_o` = 0 and `wr_en_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| oe_rfsh_ni | input | 1 | Output enable (chip enabled) / refresh clock (chip disabled), active low |
| addr_i | input | ROW_W+COL_W | Address; low ROW_W bits select the row |
| row_addr_o | output | ROW_W | Row being activated |
| col_addr_o | output | COL_W | Column select |
| row_act_o | output | 1 | Row activate strobe |
| dout_en_o | output | 1 | Drive data bus (read) |
| wr_en_o | output | 1 | Write data into the selected column |
| mode_o | output | 3 | Current mode code |

## Verification
The bench builds the block with CLK_PER_US = 4 and ROW_CYC = 3. That sets the self-refresh threshold to 32 clocks and the refresh interval to 62 clocks. With these values, pulses one clock below and exactly at the threshold can be compared directly, several self-refresh intervals can be timed, and all 256 counter rows, including the wrap, fit in a few thousand clocks. Contention is provoked by requesting an external access one clock after a refresh pulse.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_WRITE   = 3'd1,
    MODE_READ    = 3'd2,
    MODE_CE_REF  = 3'd3,
    MODE_AUTO    = 3'd4,
    MODE_SELF    = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ACT  = 2'd1,
    SQ_PRE  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/psram_mode_dec.sv
module psram_mode_dec
  import psram_pkg::*;
#(
  parameter int THRESH_CYC   = 2000,
  parameter int INTERVAL_CYC = 3906
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic rw_i,
  input  logic oe_rfsh_ni,
  output mode_e mode_o,
  output logic dout_en_o,
  output logic wr_en_o,
  output logic auto_req_o,
  output logic self_tick_o
);
  localparam int LW = (THRESH_CYC > 1) ? $clog2(THRESH_CYC) : 1;
  localparam int TW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;

  logic [LW-1:0] low_cnt_q;
  logic [TW-1:0] tmr_q;
  logic          oe_q;
  logic          rfsh_low, self_act;
  mode_e         mode_d, mode_q;
  logic          dout_q, wr_q;

  assign rfsh_low = ce_ni && !oe_rfsh_ni;
  // low_cnt saturates one below the threshold: the THRESH_CYC-th low sample enters self refresh
  assign self_act = rfsh_low && (low_cnt_q == LW'(THRESH_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      oe_q      <= 1'b1;
    end else begin
      oe_q <= oe_rfsh_ni;
      if (!rfsh_low)      low_cnt_q <= '0;
      else if (!self_act) low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 tmr_q <= '0;
    else if (!self_act)                          tmr_q <= '0;
    else if (tmr_q == TW'(INTERVAL_CYC - 1))     tmr_q <= '0;
    else                                         tmr_q <= tmr_q + 1'b1;
  end

  assign self_tick_o = self_act && (tmr_q == TW'(INTERVAL_CYC - 1));
  assign auto_req_o  = rfsh_low && oe_q;

  always_comb begin
    if (!ce_ni) begin
      if (!rw_i)            mode_d = MODE_WRITE;
      else if (!oe_rfsh_ni) mode_d = MODE_READ;
      else                  mode_d = MODE_CE_REF;
    end else if (oe_rfsh_ni) begin
      mode_d = MODE_STANDBY;
    end else if (self_act) begin
      mode_d = MODE_SELF;
    end else begin
      mode_d = MODE_AUTO;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STANDBY;
      dout_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      dout_q <= (mode_d == MODE_READ);
      wr_q   <= (mode_d == MODE_WRITE);
    end
  end

  assign mode_o    = mode_q;
  assign dout_en_o = dout_q;
  assign wr_en_o   = wr_q;
endmodule

// File: rtl/psram_ref_ctr.sv
module psram_ref_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] row_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  assign row_o = cnt_q;
endmodule

// File: rtl/psram_row_seq.sv
module psram_row_seq
  import psram_pkg::*;
#(
  parameter int ROW_W   = 8,
  parameter int ROW_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_req_i,
  input  logic [ROW_W-1:0] int_row_i,
  input  logic             ext_req_i,
  input  logic [ROW_W-1:0] ext_row_i,
  output logic             int_acc_o,
  output logic [ROW_W-1:0] row_addr_o,
  output logic             row_act_o
);
  localparam int CW = (ROW_CYC > 1) ? $clog2(ROW_CYC) : 1;

  seq_state_e       st_q;
  logic [CW-1:0]    cnt_q;
  logic [ROW_W-1:0] row_q;
  logic             int_pend_q, served_q;
  logic             ext_acc;

  assign int_acc_o = (st_q == SQ_IDLE) && int_pend_q;
  assign ext_acc   = (st_q == SQ_IDLE) && !int_pend_q && ext_req_i && !served_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_pend_q <= 1'b0;
    else         int_pend_q <= (int_pend_q && !int_acc_o) || int_req_i;
  end

  // one external cycle per enable-low period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         served_q <= 1'b0;
    else if (!ext_req_i) served_q <= 1'b0;
    else if (ext_acc)    served_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      row_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          cnt_q <= '0;
          if (int_acc_o) begin
            st_q  <= SQ_ACT;
            row_q <= int_row_i;
          end else if (ext_acc) begin
            st_q  <= SQ_ACT;
            row_q <= ext_row_i;
          end
        end
        SQ_ACT: begin
          if (cnt_q == CW'(ROW_CYC - 1)) st_q <= SQ_PRE;
          else                           cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign row_addr_o = row_q;
  assign row_act_o  = (st_q == SQ_ACT);
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int ROW_W         = 8,
  parameter int COL_W         = 7,
  parameter int CLK_PER_US    = 250,
  parameter int LONG_PULSE_US = 8,
  parameter int RETENTION_US  = 4000,
  parameter int ROW_CYC       = 3,
  localparam int ADDR_W       = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              rw_i,
  input  logic              oe_rfsh_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ROW_W-1:0]  row_addr_o,
  output logic [COL_W-1:0]  col_addr_o,
  output logic              row_act_o,
  output logic              dout_en_o,
  output logic              wr_en_o,
  output logic [2:0]        mode_o
);
  localparam int ROWS         = 1 << ROW_W;
  localparam int THRESH_CYC   = LONG_PULSE_US * CLK_PER_US;
  localparam int INTERVAL_CYC = (RETENTION_US * CLK_PER_US) / ROWS;

  mode_e            mode;
  logic             auto_req, self_tick, int_acc;
  logic [ROW_W-1:0] ctr_row;

  psram_mode_dec #(
    .THRESH_CYC  (THRESH_CYC),
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .rw_i       (rw_i),
    .oe_rfsh_ni (oe_rfsh_ni),
    .mode_o     (mode),
    .dout_en_o  (dout_en_o),
    .wr_en_o    (wr_en_o),
    .auto_req_o (auto_req),
    .self_tick_o(self_tick)
  );

  psram_ref_ctr #(.W(ROW_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (int_acc),
    .row_o (ctr_row)
  );

  psram_row_seq #(
    .ROW_W  (ROW_W),
    .ROW_CYC(ROW_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_req_i (auto_req || self_tick),
    .int_row_i (ctr_row),
    .ext_req_i (!ce_ni),
    .ext_row_i (addr_i[ROW_W-1:0]),
    .int_acc_o (int_acc),
    .row_addr_o(row_addr_o),
    .row_act_o (row_act_o)
  );

  assign col_addr_o = addr_i[ADDR_W-1:ROW_W];
  assign mode_o     = mode;
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk
  import psram_pkg::*;
#(
  parameter int ROW_W   = 8,
  parameter int ROW_CYC = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_ni,
  input logic             rw_i,
  input logic             oe_rfsh_ni,
  input logic [ROW_W-1:0] row_addr_o,
  input logic             row_act_o,
  input logic             dout_en_o,
  input logic             wr_en_o,
  input logic [2:0]       mode_o
);
  int unsigned act_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        act_len <= 0;
    else if (row_act_o) act_len <= act_len + 1;
    else                act_len <= 0;
  end

  assert_write_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(!ce_ni && !rw_i));

  assert_read_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> $past(!ce_ni && rw_i && !oe_rfsh_ni));

  assert_self_only_disabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'(MODE_SELF)) |-> $past(ce_ni && !oe_rfsh_ni));

  assert_standby_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'(MODE_STANDBY)) |-> (!dout_en_o && !wr_en_o));

  assert_row_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_act_o && $past(row_act_o)) |-> $stable(row_addr_o));

  assert_strobe_len_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(row_act_o) |-> (act_len == ROW_CYC));

  assert_precharge_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(row_act_o) |=> !row_act_o);
endmodule

bind psram_ctrl psram_ctrl_chk #(
  .ROW_W  (ROW_W),
  .ROW_CYC(ROW_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .rw_i      (rw_i),
  .oe_rfsh_ni(oe_rfsh_ni),
  .row_addr_o(row_addr_o),
  .row_act_o (row_act_o),
  .dout_en_o (dout_en_o),
  .wr_en_o   (wr_en_o),
  .mode_o    (mode_o)
);

// File: tb/psram_ctrl_tb_top.sv
`timescale 1ns/1ps
module psram_ctrl_tb_top;
  localparam int ROW_W = 8, COL_W = 7, CPU = 4, ROW_CYC = 3;
  localparam int THRESH = 8 * CPU;              // 32
  localparam int INTERVAL = (4000 * CPU) / 256; // 62
  localparam int M_STBY = 0, M_WR = 1, M_RD = 2, M_CER = 3, M_AUTO = 4, M_SELF = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, rw = 1'b1, oe_n = 1'b1;
  logic [ROW_W+COL_W-1:0] addr = '0;
  logic [ROW_W-1:0] row_addr;
  logic [COL_W-1:0] col_addr;
  logic row_act, dout_en, wr_en;
  logic [2:0] mode;

  always #2 clk = ~clk;

  psram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .CLK_PER_US(CPU),
    .LONG_PULSE_US(8), .RETENTION_US(4000), .ROW_CYC(ROW_CYC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .rw_i(rw), .oe_rfsh_ni(oe_n),
    .addr_i(addr), .row_addr_o(row_addr), .col_addr_o(col_addr),
    .row_act_o(row_act), .dout_en_o(dout_en), .wr_en_o(wr_en), .mode_o(mode)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_str = 0, wlen = 0, last_w = 0;
  int addr_log[512];
  int t_log[512];
  bit act_prev = 1'b0, saw_self = 1'b0, done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (mode == 3'(M_SELF)) saw_self = 1'b1;
      if (row_act) begin
        if (!act_prev) begin
          addr_log[n_str % 512] = int'(row_addr);
          t_log[n_str % 512]    = cyc;
          n_str++;
          wlen = 1;
        end else wlen++;
      end else if (act_prev) last_w = wlen;
      act_prev = row_act;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int n);
    oe_n = 1'b0;
    wait_cyc(n);
    oe_n = 1'b1;
    wait_cyc(10);
  endtask

  function automatic int last_addr();
    return addr_log[(n_str - 1) % 512];
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R14 mode", int'(mode), M_STBY);
    chk("R14 row_act", int'(row_act), 0);
    chk("R14 dout_en", int'(dout_en), 0);
    chk("R14 wr_en", int'(wr_en), 0);
    wait_cyc(20);
    @(negedge clk);
    chk("R9 no strobe in standby", n_str, 0);
    chk("R9 mode standby", int'(mode), M_STBY);
  endtask

  task automatic t_auto(input int exp_row);
    int n0 = n_str;
    oe_n = 1'b0;
    wait_cyc(2);
    @(negedge clk);
    chk("R5 mode auto", int'(mode), M_AUTO);
    @(posedge clk); #1;
    oe_n = 1'b1;
    wait_cyc(10);
    chk("R5 one strobe per pulse", n_str - n0, 1);
    chk("R5 counter row", last_addr(), exp_row);
  endtask

  task automatic t_write();
    int n0 = n_str;
    addr = {7'h3A, 8'h5C}; rw = 1'b0; ce_n = 1'b0;
    wait_cyc(8);
    @(negedge clk);
    chk("R2 mode write", int'(mode), M_WR);
    chk("R2 wr_en", int'(wr_en), 1);
    chk("R2 dout_en low", int'(dout_en), 0);
    chk("R1 col_addr", int'(col_addr), 'h3A);
    chk("R1 one strobe", n_str - n0, 1);
    chk("R1 row addr", last_addr(), 'h5C);
    chk("R10 strobe width", last_w, ROW_CYC);
    @(posedge clk); #1;
    ce_n = 1'b1; rw = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_read_hold();
    int n0 = n_str;
    addr = {7'h05, 8'hC3}; rw = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    wait_cyc(6);
    @(negedge clk);
    chk("R3 mode read", int'(mode), M_RD);
    chk("R3 dout_en", int'(dout_en), 1);
    chk("R3 row addr", last_addr(), 'hC3);
    // R13: refresh pin toggles while enabled
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1 oe_n = 1'b1;
      @(posedge clk); #1 oe_n = 1'b0;
    end
    wait_cyc(30);
    @(negedge clk);
    chk("R12 single strobe per CE low", n_str - n0, 1);
    @(posedge clk); #1;
    ce_n = 1'b1; oe_n = 1'b1;
    wait_cyc(4);
    @(negedge clk);
    chk("R13 no refresh from OE toggles", n_str - n0, 1);
  endtask

  task automatic t_ceref();
    int n0 = n_str;
    addr = {7'h11, 8'h7E}; rw = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
    wait_cyc(8);
    @(negedge clk);
    chk("R4 mode ce-refresh", int'(mode), M_CER);
    chk("R4 dout_en low", int'(dout_en), 0);
    chk("R4 one strobe", n_str - n0, 1);
    chk("R4 row addr", last_addr(), 'h7E);
    @(posedge clk); #1 ce_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_boundary(input int first_row);
    int n0 = n_str;
    saw_self = 1'b0;
    pulse(THRESH - 1);
    chk("R6 short pulse not self", int'(saw_self), 0);
    chk("R6 short pulse one strobe", n_str - n0, 1);
    chk("R6 short pulse row", last_addr(), first_row);
    saw_self = 1'b0;
    pulse(THRESH);
    chk("R6 threshold pulse enters self", int'(saw_self), 1);
    chk("R6 threshold pulse one strobe", n_str - n0, 2);
    chk("R6 threshold pulse row", last_addr(), first_row + 1);
  endtask

  task automatic t_self(input int first_row);
    int n0 = n_str;
    saw_self = 1'b0;
    oe_n = 1'b0;
    wait_cyc(THRESH + 3 * INTERVAL + INTERVAL / 2);
    chk("R6 mode self", int'(mode), M_SELF);
    oe_n = 1'b1;
    wait_cyc(6);
    chk("R7 self strobes", n_str - n0, 4);
    for (int i = 0; i < 4; i++)
      chk("R7 self row", addr_log[(n0 + i) % 512], (first_row + i) % 256);
    chk("R7 interval a", t_log[(n0 + 2) % 512] - t_log[(n0 + 1) % 512], INTERVAL);
    chk("R7 interval b", t_log[(n0 + 3) % 512] - t_log[(n0 + 2) % 512], INTERVAL);
    wait_cyc(3 * INTERVAL);
    @(negedge clk);
    chk("R8 no strobe after exit", n_str - n0, 4);
    chk("R8 mode standby", int'(mode), M_STBY);
  endtask

  task automatic t_arb(input int ctr_row);
    int n0 = n_str;
    oe_n = 1'b0;
    @(posedge clk); #1;
    oe_n = 1'b1; addr = {7'h00, 8'h11}; rw = 1'b1; ce_n = 1'b0;
    wait_cyc(16);
    chk("R11 two strobes", n_str - n0, 2);
    chk("R11 internal first", addr_log[n0 % 512], ctr_row);
    chk("R11 external second", addr_log[(n0 + 1) % 512], 'h11);
    chk("R11 no overlap", int'((t_log[(n0 + 1) % 512] - t_log[n0 % 512]) >= ROW_CYC + 1), 1);
    ce_n = 1'b1;
    wait_cyc(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    for (int r = 0; r < 3; r++) t_auto(r);
    t_write();
    t_read_hold();
    t_ceref();
    t_auto(3);
    for (int r = 4; r < 256; r++) pulse(2);
    chk("R5 reached row 255", last_addr(), 255);
    t_auto(0);  // R5 wrap
    t_boundary(1);
    t_self(3);
    t_arb(7);
    summary();
  end
endmodule